// File: doc/BRIEF.md
# Quad-Input Serial Page Program Controller

This block is the device-side logic of a serial memory for one write command and the commands around it. While chip select is low, a header arrives one bit per serial clock on data line 0. The header is an 8-bit opcode followed by a 24-bit address. For the page-program opcode, data bytes then arrive as nibbles on all four data lines, and they are collected into a 64-byte page buffer. The write position wraps inside the addressed page. A per-byte mask records which positions were written, so a short burst leaves the rest of the page untouched. A burst longer than a page leaves only its last 64 bytes.

When chip select returns high, the command is checked. The data must end on a whole byte, the write enable latch must be set, and the page must lie outside the region that the block-protect code guards. If all of these hold, a self-timed program cycle starts. The cycle keeps the write-in-progress flag high for a fixed number of system clocks, and the masked buffer is written into the behavioural array when the cycle ends. A write-enable command sets the latch. A status-read command shifts the status byte out on a serial output. While the cycle runs, only the status read is honoured.

All serial inputs are sampled by the system clock, which must run several times faster than the serial clock. Array contents can be observed through a combinational peek port.

Top module: `qpp_quad_prog`

## Requirements
- R1: The header is sent MSB first on dq[0]: opcode 0x32 (program), then address A23..A0. Each data byte then takes two serial clock rises: the high nibble first, then the low nibble, with dq[3] as the nibble's most significant bit.
- R2: Opcode 0x06 followed by a chip-select rise after exactly 8 header bits sets the write enable latch, provided no program cycle is running.
- R3: A program command starts a cycle only if at least one whole byte arrived, the nibble count is even, and the write enable latch is set. Otherwise the array and the latch are unchanged.
- R4: Address bits A5..A0 give the first byte offset, and writing wraps from offset 63 to offset 0 of the same page. The page index is A(5+PAGE_W)..A6, and higher address bits are ignored.
- R5: When more than 64 bytes are sent, later bytes overwrite earlier ones, so only the last 64 bytes are programmed.
- R6: Offsets that receive no byte keep their previous array contents.
- R7: The write-in-progress flag rises on the second system clock after chip select is seen high, stays high for PROG_CYCLES clocks, and the array takes the new bytes on the clock at which the flag falls.
- R8: The write enable latch is cleared when a program cycle starts.
- R9: While a cycle runs, write-enable and program commands have no effect on the latch, the array or the running cycle.
- R10: Opcode 0x05 shifts out the status byte {2'b00, bp[3:0], wel, wip} MSB first on so. Bit 7 is valid after the 8th serial clock rise, and each later rise presents the next bit.
- R11: Block-protect code 0 protects nothing. Code k>0 protects the top min(2^(k-1), page count) pages, and a program aimed at a protected page is not executed.
- R12: After reset, every array byte is 0xFF, and both wip and the write enable latch are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, oversampled by clk |
| cs_n | input | 1 | Active-low chip select |
| dq | input | 4 | Serial data lines; header on dq[0] |
| bp | input | 4 | Block-protect code |
| so | output | 1 | Serial status output |
| wip | output | 1 | Write-in-progress flag |
| peek_addr | input | PAGE_W+6 | Array observation address |
| peek_data | output | 8 | Array byte at peek_addr |

## Verification
Several behaviours are checked by assertions on every cycle. A cycle may begin only with the latch already clear. The latch cannot rise while busy. The flag falls on the clock after the commit. A cycle never starts on a protected page. The write offset wraps from 63 to 0, and each assembled byte marks its slot in the mask. Other behaviours can be shown only by the bench scenarios, which compare wip and the array against a behavioural model on every clock. These are the exact busy length, the overwrite of bursts longer than a page, the preserved bytes, the rejection of partial nibbles, empty bursts and missing write enable, and the serial status contents.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_QPROG = 8'h32;
  localparam int PAGE_BYTES = 64;
  localparam int HDR_BITS   = 32;

  // Top-of-array protection: code k guards the highest 2^(k-1) pages.
  function automatic logic page_locked(input logic [3:0] code,
                                       input int unsigned page,
                                       input int unsigned npages);
    int unsigned span;
    if (code == 4'd0) return 1'b0;
    span = 32'd1 << (code - 4'd1);
    if (span > npages) span = npages;
    return page >= (npages - span);
  endfunction

  function automatic logic [7:0] status_byte(input logic [3:0] code,
                                             input logic wel,
                                             input logic wip);
    return {2'b00, code, wel, wip};
  endfunction
endpackage

// File: rtl/qpp_rx.sv
module qpp_rx import qpp_pkg::*; #(
  parameter int PAGE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic [3:0]       dq,
  input  logic             busy_i,
  input  logic [7:0]       status_i,
  output logic             so_o,
  output logic             wren_ok_o,
  output logic             prog_ok_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [7:0]       pbuf_o [PAGE_BYTES],
  output logic [PAGE_BYTES-1:0] mask_o
);
  localparam int SH_W = 5 + PAGE_W;

  logic cs_s, cs_d, sclk_s, sclk_d;
  logic [3:0] dq_s;
  logic [5:0] cnt_q;
  logic [SH_W-1:0] sh_q;
  logic [7:0] op_q, st_sh;
  logic [5:0] off_q;
  logic [3:0] hi_q;
  logic nib_lo, got_q, sess_q;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_BYTES-1:0] mask_q;

  // named internal events
  logic sclk_rise, cs_fall, cs_rise, data_phase, byte_evt;
  logic [7:0] op_next;
  logic [SH_W:0] addr_low;

  assign sclk_rise  = sclk_s & ~sclk_d & ~cs_s;
  assign cs_fall    = ~cs_s & cs_d;
  assign cs_rise    = cs_s & ~cs_d;
  assign data_phase = (cnt_q == 6'(HDR_BITS)) && (op_q == OP_QPROG) && sess_q;
  assign byte_evt   = sclk_rise && data_phase && nib_lo;
  assign op_next    = {sh_q[6:0], dq_s[0]};
  assign addr_low   = {sh_q, dq_s[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= 1'b1; cs_d <= 1'b1; sclk_s <= 1'b0; sclk_d <= 1'b0; dq_s <= '0;
      cnt_q <= '0; sh_q <= '0; op_q <= '0; st_sh <= '0; off_q <= '0;
      hi_q <= '0; nib_lo <= 1'b0; got_q <= 1'b0; sess_q <= 1'b0;
      page_q <= '0; mask_q <= '0;
    end else begin
      cs_s <= cs_n; cs_d <= cs_s; sclk_s <= sclk; sclk_d <= sclk_s; dq_s <= dq;
      if (cs_fall) begin
        cnt_q <= '0; nib_lo <= 1'b0; got_q <= 1'b0; op_q <= '0;
        sess_q <= ~busy_i;
        if (!busy_i) mask_q <= '0;
      end else if (sclk_rise) begin
        if (cnt_q < 6'(HDR_BITS)) begin
          cnt_q <= cnt_q + 6'd1;
          sh_q  <= {sh_q[SH_W-2:0], dq_s[0]};
          if (cnt_q == 6'd7) begin
            op_q <= op_next;
            if (op_next == OP_RDSR) st_sh <= status_i;
          end
          if (cnt_q == 6'(HDR_BITS - 1)) begin
            off_q  <= addr_low[5:0];
            page_q <= addr_low[6 +: PAGE_W];
          end
        end
        if (op_q == OP_RDSR && cnt_q >= 6'd8) st_sh <= {st_sh[6:0], st_sh[7]};
        if (data_phase) begin
          if (!nib_lo) begin
            hi_q   <= dq_s;
            nib_lo <= 1'b1;
          end else begin
            mask_q[off_q] <= 1'b1;
            off_q  <= off_q + 6'd1;
            nib_lo <= 1'b0;
            got_q  <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_evt) pbuf_o[off_q] <= {hi_q, dq_s};
  end

  assign so_o      = (op_q == OP_RDSR) ? st_sh[7] : 1'b0;
  assign wren_ok_o = cs_rise && sess_q && (op_q == OP_WREN) && (cnt_q == 6'd8);
  assign prog_ok_o = cs_rise && data_phase && got_q && !nib_lo;
  assign page_o    = page_q;
  assign mask_o    = mask_q;

  // R4
  off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt && off_q == 6'd63 |=> off_q == 6'd0);
  // R6
  mask_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |=> mask_q[$past(off_q)] && got_q);
endmodule

// File: rtl/qpp_core.sv
module qpp_core import qpp_pkg::*; #(
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_ok_i,
  input  logic              prog_ok_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [3:0]        bp_i,
  input  logic [7:0]        pbuf_i [PAGE_BYTES],
  input  logic [PAGE_BYTES-1:0] mask_i,
  input  logic [PAGE_W+5:0] peek_addr_i,
  output logic [7:0]        peek_data_o,
  output logic              wip_o,
  output logic              wel_o
);
  localparam int NPAGES = 1 << PAGE_W;
  localparam int NBYTES = NPAGES * PAGE_BYTES;
  localparam int CW     = $clog2(PROG_CYCLES + 1);

  logic wip_q, wel_q;
  logic [CW-1:0] tmr_q;
  logic [PAGE_W-1:0] pg_q;
  logic [7:0] mem [NBYTES];

  logic locked, start_evt, commit_evt;
  assign locked     = page_locked(bp_i, 32'(page_i), NPAGES);
  assign start_evt  = prog_ok_i && wel_q && !locked && !wip_q;
  assign commit_evt = wip_q && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q <= 1'b0; wel_q <= 1'b0; tmr_q <= '0; pg_q <= '0;
    end else begin
      if (start_evt) begin
        wip_q <= 1'b1;
        tmr_q <= CW'(PROG_CYCLES - 1);
        wel_q <= 1'b0;
        pg_q  <= page_i;
      end else if (wip_q) begin
        if (tmr_q == '0) wip_q <= 1'b0;
        else             tmr_q <= tmr_q - CW'(1);
      end
      if (wren_ok_i && !wip_q) wel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
    end else if (commit_evt) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask_i[i]) mem[{pg_q, 6'(i)}] <= pbuf_i[i];
    end
  end

  assign peek_data_o = mem[peek_addr_i];
  assign wip_o = wip_q;
  assign wel_o = wel_q;

  // R8
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> !wel_q);
  // R9
  busy_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && !wel_q) |=> !wel_q);
  // R7
  commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !wip_q);
  // R11
  lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> !page_locked($past(bp_i), 32'(pg_q), NPAGES));
endmodule

// File: rtl/qpp_quad_prog.sv
module qpp_quad_prog import qpp_pkg::*; #(
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic [3:0]        dq,
  input  logic [3:0]        bp,
  output logic              so,
  output logic              wip,
  input  logic [PAGE_W+5:0] peek_addr,
  output logic [7:0]        peek_data
);
  logic wren_ok, prog_ok, wel;
  logic [PAGE_W-1:0] page;
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [7:0] status;

  assign status = status_byte(bp, wel, wip);

  qpp_rx #(.PAGE_W(PAGE_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dq(dq),
    .busy_i(wip), .status_i(status), .so_o(so),
    .wren_ok_o(wren_ok), .prog_ok_o(prog_ok), .page_o(page),
    .pbuf_o(pbuf), .mask_o(mask)
  );

  qpp_core #(.PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) core_i (
    .clk(clk), .rst_n(rst_n), .wren_ok_i(wren_ok), .prog_ok_i(prog_ok),
    .page_i(page), .bp_i(bp), .pbuf_i(pbuf), .mask_i(mask),
    .peek_addr_i(peek_addr), .peek_data_o(peek_data),
    .wip_o(wip), .wel_o(wel)
  );
endmodule

// File: tb/qpp_quad_prog_tb_top.sv
`timescale 1ns/1ps
module qpp_quad_prog_tb_top;
  localparam int PW = 3;
  localparam int PC = 600;
  localparam int NB = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1;
  logic [3:0] dq = '0, bp = '0;
  logic so, wip;
  logic [PW+5:0] peek_addr = '0;
  logic [7:0] peek_data;

  qpp_quad_prog #(.PAGE_W(PW), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dq(dq), .bp(bp),
    .so(so), .wip(wip), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int marr [NB];
  int pend_v [64];
  bit pend_m [64];
  int pend_pg = 0;
  bit mwip = 0, mwel = 0, run = 0, hold = 0;
  int mcnt = 0, arm = 0;
  logic [PW+5:0] req = '0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic bit bench_locked(int pg, int code);
    int count = 1;
    if (code == 0) return 0;
    repeat (code - 1) count = count * 2;
    if (count > 8) count = 8;
    return pg >= 8 - count;
  endfunction

  // behavioural model of busy timing and the array
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) marr[i] = 8'hFF;
      mwip = 0; mwel = 0; arm = 0;
    end else if (arm > 0) begin
      arm = arm - 1;
      if (arm == 0) begin mwip = 1; mcnt = PC - 1; mwel = 0; end
    end else if (mwip) begin
      if (mcnt == 0) begin
        mwip = 0;
        for (int i = 0; i < 64; i++) if (pend_m[i]) marr[pend_pg*64 + i] = pend_v[i];
      end else mcnt = mcnt - 1;
    end
  end

  // per-clock comparison (R7, R12)
  always @(negedge clk) begin
    if (rst_n && run) begin
      chk(wip === mwip, "R7 wip", int'(wip), int'(mwip));
      chk(peek_data === 8'(marr[peek_addr]), "R12 array", int'(peek_data), marr[peek_addr]);
    end
    peek_addr <= hold ? req : peek_addr + 1'b1;
  end

  task automatic bit_io(input logic [3:0] v, output logic s);
    @(negedge clk) dq = v;
    @(negedge clk) sclk = 1'b1;
    repeat (3) @(negedge clk);
    s = so;
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io({3'b000, b[i]}, s);
  endtask

  task automatic cs_begin();
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_end(input bit accept);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    if (accept) arm = 2;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_wren();
    bit ok = !mwip;
    cs_begin(); send_byte(8'h06); cs_end(0);
    if (ok) mwel = 1;
  endtask

  task automatic read_status(input string tag);
    logic [7:0] st; logic s;
    logic [7:0] exp;
    exp = {2'b00, bp, mwel, mwip};
    cs_begin();
    for (int i = 7; i >= 0; i--) begin
      bit_io({3'b000, i == 7 || i == 5 ? 1'b0 : (i == 0 || i == 2 ? 1'b1 : 1'b0)}, s);
    end
    st[7] = s;
    for (int i = 6; i >= 0; i--) begin bit_io(4'h0, s); st[i] = s; end
    cs_end(0);
    chk(st === exp, tag, int'(st), int'(exp));
  endtask

  function automatic logic [7:0] pat(int base, int i);
    return 8'((base + i * 7) & 255);
  endfunction

  task automatic do_prog(input logic [23:0] a, input int nb, input int base, input bit odd);
    bit sess = !mwip;
    bit acc;
    logic s;
    int pg = int'(a[8:6]);
    int off = int'(a[5:0]);
    cs_begin();
    send_byte(8'h32); send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b = pat(base, i);
      bit_io(b[7:4], s); bit_io(b[3:0], s);
    end
    if (odd) bit_io(4'hA, s);
    acc = sess && nb >= 1 && !odd && mwel && !bench_locked(pg, int'(bp));
    if (acc) begin
      for (int i = 0; i < 64; i++) pend_m[i] = 0;
      for (int i = 0; i < nb; i++) begin
        pend_v[(off + i) % 64] = int'(pat(base, i));
        pend_m[(off + i) % 64] = 1;
      end
      pend_pg = pg;
    end
    cs_end(acc);
  endtask

  task automatic wait_idle();
    while (mwip || arm > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic peek_chk(input int a, input int exp, input string tag);
    @(posedge clk); hold = 1; req = 9'(a);
    @(posedge clk); @(posedge clk); #1;
    chk(peek_data === 8'(exp), tag, int'(peek_data), exp);
    hold = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run = 1;
    repeat (2) @(negedge clk);
    // R12: reset state
    chk(wip === 1'b0, "R12 wip", int'(wip), 0);
    peek_chk(100, 8'hFF, "R12 erased");
    read_status("R10 R12 status after reset");
    // R3: no write enable -> rejected
    do_prog(24'h000040, 2, 8'h01, 0); wait_idle();
    peek_chk(64, 8'hFF, "R3 no wel");
    // R2: write enable
    do_wren(); read_status("R2 wel set");
    // R1 R4: wrap inside page 1, offset 0x3C
    do_prog(24'hFF807C, 6, 8'h11, 0);
    read_status("R8 wel cleared busy");
    wait_idle();
    peek_chk(64 + 60, int'(pat(8'h11, 0)), "R1 first byte");
    peek_chk(64 + 1, int'(pat(8'h11, 5)), "R4 wrap");
    // R5: 70 bytes into page 2 offset 5
    do_wren(); do_prog(24'h000085, 70, 8'h20, 0); wait_idle();
    peek_chk(128 + 5, int'(pat(8'h20, 64)), "R5 overwrite");
    peek_chk(128 + 4, int'(pat(8'h20, 63)), "R5 last");
    peek_chk(128 + 10, int'(pat(8'h20, 69)), "R5 tail");
    peek_chk(128 + 11, int'(pat(8'h20, 6)), "R5 kept");
    // R6: one byte, neighbours untouched
    do_wren(); do_prog(24'h00004A, 1, 8'h5A, 0); wait_idle();
    peek_chk(64 + 10, 8'h5A, "R6 written");
    peek_chk(64 + 11, 8'hFF, "R6 untouched");
    peek_chk(64 + 1, int'(pat(8'h11, 5)), "R6 old kept");
    // R3: odd nibble count and empty burst
    do_wren(); do_prog(24'h000100, 2, 8'h33, 1); wait_idle();
    peek_chk(256, 8'hFF, "R3 odd nibble");
    read_status("R3 wel kept");
    do_prog(24'h000000, 0, 0, 0); wait_idle();
    peek_chk(0, 8'hFF, "R3 empty");
    // R11: code 2 guards pages 6 and 7
    bp = 4'd2;
    do_prog(24'h0001C3, 1, 8'h77, 0); wait_idle();
    peek_chk(7 * 64 + 3, 8'hFF, "R11 locked");
    do_prog(24'h000143, 1, 8'h66, 0); wait_idle();
    peek_chk(5 * 64 + 3, 8'h66, "R11 open");
    bp = 4'd0;
    // R9: commands during busy
    do_wren(); do_prog(24'h0000C0, 1, 8'h44, 0);
    do_wren();
    read_status("R9 busy status");
    do_prog(24'h000100, 1, 8'h99, 0);
    chk(wip === 1'b1, "R9 still busy", int'(wip), 1);
    wait_idle();
    read_status("R9 wel not set");
    peek_chk(256, 8'hFF, "R9 prog ignored");
    peek_chk(192, 8'h44, "R9 first done");
    run = 0;
    finish_run();
  end
endmodule